// File: doc/BRIEF.md
# Direct-Mapped Write-Back/Write-Through Cache

This block is a direct-mapped cache between a word-oriented CPU port and a slower main-memory port. A 32-bit byte address is split into fields. The two lowest bits are a byte offset and are ignored. Above them sit the word-within-block bits, then the index bits that pick the single slot a block may occupy, and the remaining upper bits form the tag. Each slot keeps a tag, a valid flag and a dirty flag. The default geometry is small: 4 words per block and 8 blocks. The field order stays fixed when the geometry parameters are raised, up to 512-word blocks and 128 slots.

A run-time input, `wr_delayed`, selects the write policy for each write: 1 means delayed write and 0 means write-through. A delayed write that hits only updates the cache and marks the slot dirty. A write-through write updates the cache and then performs one memory write. On a miss, a dirty victim is first copied back word by word to the address its stored tag names. The whole new block is then fetched, and the CPU request completes as a hit.

The memory side uses a request/acknowledge handshake that moves one word per acknowledged beat. The CPU must hold its request and its inputs steady while `cpu_busy` is high.

Top module: `dm_cache`

## Requirements
- R1: Address bits [1:0] are ignored. Bits [2+WB-1:2] select the word, the next IB bits select the slot, and bits [31:2+WB+IB] are the tag (defaults WB=2, IB=3). Two addresses that differ only in bits [1:0] read the same word with no memory traffic.
- R2: After reset every slot is invalid and clean. `cpu_busy`, `cpu_rvalid` and `mem_req` are 0, and the first access to any address misses.
- R3: A read is accepted on a rising edge where `cpu_req`=1 and `cpu_busy`=0. `cpu_rvalid` is 1 with the addressed word on `cpu_rdata` in the next cycle only, and at no other time.
- R4: `cpu_busy` is high whenever a request misses and throughout the write-back, refill and write-through memory activity.
- R5: With `wr_delayed`=0, a write that hits updates the cached word and performs exactly one memory write of that word to the same address.
- R6: With `wr_delayed`=1, a write that hits updates only the cache, marks the slot dirty and causes no memory beat.
- R7: A miss whose victim slot is invalid or clean performs exactly one read beat per word of the block and no write beats.
- R8: A miss whose victim slot is valid and dirty first writes every word of the old block to the old tag's addresses. It then refills the block, and the refilled slot is clean.
- R9: A write miss allocates the block by refilling it, then applies the write under the current policy.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we` and `mem_addr` stay unchanged into the next cycle.
- R11: The policy is sampled per write. A slot left dirty before a switch to write-through stays dirty and is still written back when it is evicted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_delayed | input | 1 | 1 = delayed write with dirty marking, 0 = write-through |
| cpu_req | input | 1 | CPU access request, held until accepted |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | CPU byte address |
| cpu_wdata | input | 32 | CPU write word |
| cpu_rdata | output | 32 | Read word, valid with cpu_rvalid |
| cpu_rvalid | output | 1 | Read data strobe, one cycle after acceptance |
| cpu_busy | output | 1 | Request cannot be accepted this cycle |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = memory write beat, 0 = read beat |
| mem_addr | output | 32 | Memory byte address of the beat |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Memory read word, valid with mem_ack |
| mem_ack | input | 1 | Beat completes on this edge |

## Verification
The bench aims at the eviction of a dirty slot by a conflicting tag. A design that skipped the copy-back, or wrote the old words to the new tag's addresses, would leave main memory disagreeing with the reference copy. Write misses under both policies are mixed with a policy switch while dirty slots exist. A design that cleared dirty state on the switch, or left the refilled slot dirty, would show the wrong number of write beats on a later eviction. Byte-offset aliasing and a hit that follows a refill expose a wrong field split or a stale read, because the read strobe or the data would be off by one cycle or by one word.

// File: rtl/dm_cache.sv
module dm_cache #(
  parameter int WORD_BITS  = 2,
  parameter int INDEX_BITS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_delayed,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        cpu_rvalid,
  output logic        cpu_busy,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack
);
  localparam int WPB   = 1 << WORD_BITS;
  localparam int NBLK  = 1 << INDEX_BITS;
  localparam int TAG_W = 30 - WORD_BITS - INDEX_BITS;
  localparam int LINES = WPB * NBLK;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL, S_WT} st_t;
  st_t st;

  logic [31:0]           data_q [LINES];
  logic [TAG_W-1:0]      tag_q  [NBLK];
  logic [NBLK-1:0]       vld_q, dty_q;
  logic [WORD_BITS-1:0]  cnt;
  logic [INDEX_BITS-1:0] m_idx;
  logic [TAG_W-1:0]      m_tag;
  logic [31:0]           wt_addr, wt_data;

  wire [TAG_W-1:0]      a_tag  = cpu_addr[31 -: TAG_W];
  wire [INDEX_BITS-1:0] a_idx  = cpu_addr[2+WORD_BITS +: INDEX_BITS];
  wire [WORD_BITS-1:0]  a_word = cpu_addr[2 +: WORD_BITS];
  wire                  unused_offset = ^cpu_addr[1:0];

  wire hit    = vld_q[a_idx] && (tag_q[a_idx] == a_tag);
  wire accept = cpu_req && hit && (st == S_IDLE);
  wire last   = &cnt;

  assign cpu_busy  = (st != S_IDLE) || (cpu_req && !hit);
  assign mem_req   = (st != S_IDLE);
  assign mem_we    = (st == S_WB) || (st == S_WT);
  assign mem_addr  = (st == S_WT) ? wt_addr
                   : {(st == S_WB) ? tag_q[m_idx] : m_tag, m_idx, cnt, 2'b00};
  assign mem_wdata = (st == S_WT) ? wt_data : data_q[{m_idx, cnt}];

  always_ff @(posedge clk) begin
    if (accept && cpu_we)
      data_q[{a_idx, a_word}] <= cpu_wdata;
    else if (st == S_FILL && mem_ack)
      data_q[{m_idx, cnt}] <= mem_rdata;
    if (st == S_FILL && mem_ack && last)
      tag_q[m_idx] <= m_tag;
    if (accept)
      cpu_rdata <= data_q[{a_idx, a_word}];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      vld_q      <= '0;
      dty_q      <= '0;
      cnt        <= '0;
      m_idx      <= '0;
      m_tag      <= '0;
      wt_addr    <= '0;
      wt_data    <= '0;
      cpu_rvalid <= 1'b0;
    end else begin
      cpu_rvalid <= accept && !cpu_we;
      case (st)
        S_IDLE: begin
          if (accept) begin
            if (cpu_we) begin
              if (wr_delayed) dty_q[a_idx] <= 1'b1;
              else begin
                wt_addr <= {cpu_addr[31:2], 2'b00};
                wt_data <= cpu_wdata;
                st      <= S_WT;
              end
            end
          end else if (cpu_req) begin
            m_idx <= a_idx;
            m_tag <= a_tag;
            cnt   <= '0;
            st    <= (vld_q[a_idx] && dty_q[a_idx]) ? S_WB : S_FILL;
          end
        end
        S_WB: if (mem_ack) begin
          cnt <= cnt + 1'b1;
          if (last) st <= S_FILL;
        end
        S_FILL: if (mem_ack) begin
          cnt <= cnt + 1'b1;
          if (last) begin
            vld_q[m_idx] <= 1'b1;
            dty_q[m_idx] <= 1'b0;
            st           <= S_IDLE;
          end
        end
        S_WT: if (mem_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |-> $past(cpu_req && !cpu_we && !cpu_busy));

  // R6
  delayed_sets_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && !cpu_busy && wr_delayed) |=> (dty_q[$past(a_idx)] && !mem_req));

  // R5
  wt_issues_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && !cpu_busy && !wr_delayed)
      |=> (mem_req && mem_we && mem_addr[31:2] == $past(cpu_addr[31:2])
           && mem_wdata == $past(cpu_wdata)));

  // R10
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R8
  wb_only_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WB) |-> (vld_q[m_idx] && dty_q[m_idx]));

  // R4
  busy_during_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !hit) |-> cpu_busy);
endmodule

// File: tb/dm_cache_test.sv
`timescale 1ns/1ps
module dm_cache_test;
  localparam int WB = 2, IB = 3, WPB = 4, NB = 8;

  logic clk = 0, rst_n = 0;
  logic wr_delayed = 1, cpu_req = 0, cpu_we = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0, cpu_rdata, mem_addr, mem_wdata;
  logic [31:0] mem_rdata = 0;
  logic cpu_rvalid, cpu_busy, mem_req, mem_we;
  logic mem_ack = 0;

  int total = 0, bad = 0, nwr = 0, nrd = 0;
  bit finished = 0;

  logic [31:0] mem     [int unsigned];
  logic [31:0] exp_mem [int unsigned];
  bit          mv [NB];
  bit          md [NB];
  int unsigned mt [NB];
  logic [31:0] mdat [NB*WPB];

  always #5 clk = ~clk;

  dm_cache #(.WORD_BITS(WB), .INDEX_BITS(IB)) uut (
    .clk(clk), .rst_n(rst_n), .wr_delayed(wr_delayed), .cpu_req(cpu_req),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid), .cpu_busy(cpu_busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack));

  function automatic logic [31:0] initv(int unsigned wa);
    return wa * 32'h9E3779B1 + 32'h5A5A;
  endfunction
  function automatic logic [31:0] rd_mem(int unsigned wa);
    return mem.exists(wa) ? mem[wa] : initv(wa);
  endfunction
  function automatic logic [31:0] rd_exp(int unsigned wa);
    return exp_mem.exists(wa) ? exp_mem[wa] : initv(wa);
  endfunction
  function automatic logic [31:0] mk(int unsigned tag, int unsigned idx, int unsigned w);
    return (tag << (2+WB+IB)) | (idx << (2+WB)) | (w << 2);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder: one beat per ack, ack every other cycle
  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      if (mem_we) begin mem[mem_addr >> 2] = mem_wdata; nwr++; end
      else nrd++;
    end
    mem_ack <= mem_req && !mem_ack;
  end

  // R10 beat hold monitor, compared on every clock
  bit p_hold = 0;
  logic [31:0] p_addr = 0;
  logic p_we = 0;
  always @(negedge clk) begin
    mem_rdata = rd_mem(mem_addr >> 2);
    if (rst_n && !finished) begin
      if (p_hold) chk(mem_req && mem_addr == p_addr && mem_we == p_we, "R10", mem_addr, p_addr);
      p_hold = mem_req && !mem_ack;
      p_addr = mem_addr;
      p_we   = mem_we;
    end
  end

  task automatic access(bit we, logic [31:0] addr, logic [31:0] data, bit dly, string req);
    int unsigned wa = addr >> 2;
    int unsigned idx = (wa >> WB) % NB;
    int unsigned tag = wa >> (WB+IB);
    int unsigned w = wa % WPB;
    int exp_wr = 0, exp_rd = 0, w0, r0;
    logic [31:0] exp_d = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = addr; cpu_wdata = data; wr_delayed = dly;
    w0 = nwr; r0 = nrd;
    if (!(mv[idx] && mt[idx] == tag)) begin
      if (mv[idx] && md[idx]) begin
        for (int k = 0; k < WPB; k++)
          exp_mem[(mt[idx] << (WB+IB)) | (idx << WB) | k] = mdat[idx*WPB+k];
        exp_wr += WPB;
      end
      for (int k = 0; k < WPB; k++)
        mdat[idx*WPB+k] = rd_exp((tag << (WB+IB)) | (idx << WB) | k);
      exp_rd = WPB;
      mv[idx] = 1; mt[idx] = tag; md[idx] = 0;
    end
    if (we) begin
      mdat[idx*WPB+w] = data;
      if (dly) md[idx] = 1;
      else begin exp_mem[wa] = data; exp_wr++; end
    end else exp_d = mdat[idx*WPB+w];
    #1;
    while (cpu_busy) begin
      @(negedge clk);
      chk(!cpu_rvalid, "R4", {31'd0, cpu_rvalid}, 0);
      #1;
    end
    @(negedge clk);
    cpu_req = 0;
    chk(cpu_rvalid == !we, "R3", {31'd0, cpu_rvalid}, {31'd0, !we});
    if (!we) chk(cpu_rdata == exp_d, req, cpu_rdata, exp_d);
    while (cpu_busy) @(negedge clk);
    chk(nwr - w0 == exp_wr, req, nwr - w0, exp_wr);
    chk(nrd - r0 == exp_rd, req, nrd - r0, exp_rd);
    if (we && !dly) chk(rd_mem(wa) == data, "R5", rd_mem(wa), data);
  endtask

  initial begin
    #(200000*10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h1234_5678;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk(!cpu_busy && !cpu_rvalid && !mem_req, "R2", {cpu_busy, cpu_rvalid, mem_req}, 0);
    rst_n = 1;
    access(0, mk(1,2,0), 0, 1, "R2 R7 first read miss");
    access(0, mk(1,2,3) | 32'h1, 0, 1, "R1 offset ignored hit");
    access(0, mk(1,2,3) | 32'h3, 0, 1, "R1 offset alias");
    access(1, mk(1,2,1), 32'hDEAD_0001, 1, "R6 delayed hit");
    access(0, mk(1,2,1), 0, 1, "R6 R3 read back");
    access(0, mk(2,2,0), 0, 1, "R8 dirty eviction");
    chk(rd_mem((1 << (WB+IB)) | (2 << WB) | 1) == 32'hDEAD_0001, "R8",
        rd_mem((1 << (WB+IB)) | (2 << WB) | 1), 32'hDEAD_0001);
    access(1, mk(2,2,2), 32'hBEEF_0002, 0, "R5 write-through hit");
    access(0, mk(2,2,2), 0, 1, "R5 read after write-through");
    access(1, mk(5,4,1), 32'hC0DE_0003, 1, "R9 delayed write miss");
    access(0, mk(6,4,0), 0, 1, "R9 R8 evict allocated write");
    access(1, mk(7,5,3), 32'hABCD_0004, 0, "R9 write-through write miss");
    access(1, mk(3,6,0), 32'h1111_0005, 1, "R11 make dirty");
    access(1, mk(3,6,1), 32'h2222_0006, 0, "R11 write-through on dirty slot");
    access(0, mk(4,6,0), 0, 0, "R11 dirty survives switch");
    for (int i = 0; i < 60; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      access(seed[20], mk(seed[30:28], seed[26:24], seed[17:16]),
             seed ^ 32'h0F0F_F0F0, seed[21], "R7 R8 mixed pattern");
    end
    foreach (exp_mem[k]) chk(rd_mem(k) == exp_mem[k], "R8", rd_mem(k), exp_mem[k]);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule